// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policy

This block is a small direct-mapped data cache placed between one requester and a slower backing memory. Each line holds one data word along with a tag, a valid flag and a dirty flag. The low address bits select the line. The remaining bits form the tag, which records which memory word the line copies. Only one request is in flight at a time. A request is accepted with a valid/ready handshake. Every accepted request produces exactly one single-cycle response pulse, and a read returns its data on that pulse.

A build parameter picks one of two write-policy pairings:
- **Write-back with allocation.** Writes stay in the cache and mark the line dirty. Dirty data goes to memory only when the line is evicted or flushed.
- **Write-through without allocation.** Every write goes to memory at once. Lines are only filled by read misses.

The requester can also pulse a flush command. The flush walks every line, writes back each dirty one, clears its dirty flag, and pulses a done strobe at the end.

The memory port is a request/acknowledge interface of any latency. The controller holds its request steady until the acknowledge arrives. After reset, an indexed sweep invalidates every line before the first request is accepted.

Top module: `wpc_cache_top`

## Requirements
- R1: After reset is released, `req_ready` stays low while every line is invalidated by a sweep, then rises; the first read of any address after that is a miss.
- R2: A read whose line is valid with a matching tag (tag = `req_addr[ADDR_W-1:IDX_W]`, line index = `req_addr[IDX_W-1:0]`) returns the cached word and issues no memory transaction.
- R3: A read miss issues one memory read of the requested address, returns that word, and leaves the line valid so that the next read of it hits.
- R4: In write-through mode every write, hit or miss, performs exactly one memory write of the address and data before its response; on a hit the cached line is updated as well.
- R5: In write-through mode a write miss performs no memory read and does not fill the line, so a later read of that address misses.
- R6: In write-back mode a write hit updates only the cached line and marks it dirty; memory keeps its old value and no memory write occurs.
- R7: In write-back mode a miss whose victim line is valid and dirty first writes the victim word to address {victim tag, index}, then reads the requested word; the write comes strictly before the read.
- R8: In write-back mode a write miss reads the line from memory, then merges the write data as a dirty hit; no memory write occurs at that time.
- R9: A victim that is valid and clean is replaced without any memory write.
- R10: A flush writes back every dirty line, clears its dirty flag and ends with a one-cycle `flush_done` pulse; a flush with no dirty lines performs no memory write.
- R11: From the cycle `flush_req` is raised until `flush_done`, `req_ready` is low and no request is accepted.
- R12: Once `mem_req` is raised, it and `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle `mem_ack` is high.
- R13: Each accepted request yields exactly one `rsp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe for the accepted request |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_valid` on reads |
| flush_req | input | 1 | Pulse to write back all dirty lines |
| flush_done | output | 1 | One-cycle pulse when the flush scan has finished |
| mem_req | output | 1 | Memory transaction request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transaction complete |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
Two copies of the controller are driven, one per write policy, against a memory model with several cycles of latency.

**Read patterns.** A repeated read of one address tells a fill apart from a hit by the memory read count. A read to a second tag on the same index forces an eviction. On a dirty victim, the write-before-read ordering and the written-back value are checked. On a clean victim, the absence of a write is checked.

**Write patterns.** Writes to resident and to absent addresses separate the four policy cases by the memory read and write counts and by the backing-memory contents.

**Flush patterns.** Flushes with one dirty line and with none separate real write-back from an idle scan.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_FILL,
    ST_WRITE_THROUGH,
    ST_FLUSH_SCAN,
    ST_RESPOND
  } wpc_state_e;

endpackage

// File: rtl/wpc_rst_sync.sv
module wpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/wpc_line_store.sv
module wpc_line_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINES-1:0]  dirty_vec
);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic line_en;
    assign line_en = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (line_en) begin
        valid_q[i] <= wr_valid;
        dirty_q[i] <= wr_dirty;
        tag_q[i]   <= wr_tag;
        data_q[i]  <= wr_data;
      end
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_dirty  = dirty_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_data   = data_q[rd_idx];
  assign dirty_vec = dirty_q & valid_q;

endmodule

// File: rtl/wpc_fsm.sv
module wpc_fsm
  import wpc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 2,
  parameter bit WRITE_BACK = 1'b1,
  localparam int TAG_W     = ADDR_W - IDX_W,
  localparam int LINES     = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              flush_req,
  output logic              flush_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              wr_valid,
  output logic              wr_dirty,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  wpc_state_e        st_q, st_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic              flushing_q, flushing_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              req_cap;

  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              tag_hit;
  logic              victim_dirty;

  assign cur_idx      = addr_q[IDX_W-1:0];
  assign cur_tag      = addr_q[ADDR_W-1:IDX_W];
  assign rd_idx       = flushing_q ? ptr_q : cur_idx;
  assign tag_hit      = rd_valid && (rd_tag == cur_tag);
  assign victim_dirty = rd_valid && rd_dirty;

  assign req_ready = (st_q == ST_IDLE) && !flush_req;
  assign req_cap   = req_valid && req_ready;
  assign rsp_valid = (st_q == ST_RESPOND);
  assign rsp_rdata = rdata_q;

  // next-state and output decode
  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    flushing_d = flushing_q;
    rdata_d    = rdata_q;
    rdata_en   = 1'b0;
    flush_done = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = addr_q;
    mem_wdata  = wdata_q;
    wr_en      = 1'b0;
    wr_idx     = rd_idx;
    wr_valid   = rd_valid;
    wr_dirty   = rd_dirty;
    wr_tag     = rd_tag;
    wr_data    = rd_data;

    unique case (st_q)
      ST_INIT: begin
        wr_en    = 1'b1;
        wr_idx   = ptr_q;
        wr_valid = 1'b0;
        wr_dirty = 1'b0;
        ptr_d    = ptr_q + 1'b1;
        if (ptr_q == LAST_IDX) st_d = ST_IDLE;
      end

      ST_IDLE: begin
        if (flush_req) begin
          st_d       = ST_FLUSH_SCAN;
          ptr_d      = '0;
          flushing_d = 1'b1;
        end else if (req_valid) begin
          st_d = ST_LOOKUP;
        end
      end

      ST_LOOKUP: begin
        if (WRITE_BACK) begin
          if (tag_hit) begin
            if (we_q) begin
              wr_en    = 1'b1;
              wr_data  = wdata_q;
              wr_dirty = 1'b1;
            end else begin
              rdata_d  = rd_data;
              rdata_en = 1'b1;
            end
            st_d = ST_RESPOND;
          end else if (victim_dirty) begin
            st_d = ST_WRITEBACK;
          end else begin
            st_d = ST_FILL;
          end
        end else begin
          if (we_q) begin
            if (tag_hit) begin
              wr_en    = 1'b1;
              wr_data  = wdata_q;
              wr_dirty = 1'b0;
            end
            st_d = ST_WRITE_THROUGH;
          end else if (tag_hit) begin
            rdata_d  = rd_data;
            rdata_en = 1'b1;
            st_d     = ST_RESPOND;
          end else begin
            st_d = ST_FILL;
          end
        end
      end

      ST_WRITEBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {rd_tag, rd_idx};
        mem_wdata = rd_data;
        if (mem_ack) begin
          if (flushing_q) begin
            wr_en    = 1'b1;
            wr_dirty = 1'b0;
            st_d     = ST_FLUSH_SCAN;
          end else begin
            st_d = ST_FILL;
          end
        end
      end

      ST_FILL: begin
        mem_req = 1'b1;
        mem_we  = 1'b0;
        if (mem_ack) begin
          wr_en    = 1'b1;
          wr_idx   = cur_idx;
          wr_valid = 1'b1;
          wr_tag   = cur_tag;
          wr_data  = we_q ? wdata_q : mem_rdata;
          wr_dirty = we_q;
          rdata_d  = mem_rdata;
          rdata_en = 1'b1;
          st_d     = ST_RESPOND;
        end
      end

      ST_WRITE_THROUGH: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) st_d = ST_RESPOND;
      end

      ST_FLUSH_SCAN: begin
        if (victim_dirty) begin
          st_d = ST_WRITEBACK;
        end else if (ptr_q == LAST_IDX) begin
          flush_done = 1'b1;
          flushing_d = 1'b0;
          ptr_d      = '0;
          st_d       = ST_IDLE;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end

      ST_RESPOND: begin
        st_d = ST_IDLE;
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_INIT;
      ptr_q      <= '0;
      flushing_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ptr_q      <= ptr_d;
      flushing_q <= flushing_d;
    end
  end

  // request capture, enabled on handshake
  always_ff @(posedge clk) begin
    if (req_cap) begin
      addr_q  <= req_addr;
      we_q    <= req_we;
      wdata_q <= req_wdata;
    end
  end

  // read data capture, enabled on hit or fill
  always_ff @(posedge clk) begin
    if (rdata_en) rdata_q <= rdata_d;
  end

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R13
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing_q || flush_req) |-> !req_ready);

  // R7
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !flushing_q && (st_q == ST_WRITEBACK)) |=> (mem_req && !mem_we));

endmodule

// File: rtl/wpc_cache_top.sv
module wpc_cache_top #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 2,
  parameter bit WRITE_BACK = 1'b1,
  localparam int TAG_W     = ADDR_W - IDX_W,
  localparam int LINES     = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              flush_req,
  output logic              flush_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              rst_sync_n;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic              rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_valid;
  logic              wr_dirty;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic [LINES-1:0]  dirty_vec;

  wpc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wpc_line_store #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk       (clk),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_tag    (rd_tag),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_dirty  (wr_dirty),
    .wr_tag    (wr_tag),
    .wr_data   (wr_data),
    .dirty_vec (dirty_vec)
  );

  wpc_fsm #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .WRITE_BACK (WRITE_BACK)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_we     (req_we),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_dirty   (rd_dirty),
    .rd_tag     (rd_tag),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .wr_dirty   (wr_dirty),
    .wr_tag     (wr_tag),
    .wr_data    (wr_data)
  );

  // R10
  flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_done |-> ($countones(dirty_vec) == 0));

  // R4 write-through never leaves a dirty line
  if (!WRITE_BACK) begin : g_wt_chk
    // R4
    wt_nodirty_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!req_ready && !mem_req) |-> ($countones(dirty_vec) == 0));
  end

endmodule

// File: tb/sim_wpc_cache_top.sv
module sim_wpc_cache_top;

  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int LAT = 3;

  typedef struct {
    bit          rd;
    logic [DW-1:0] d;
    string       tag;
  } exp_t;

  logic clk;
  logic rst_n;

  logic          req_valid [2];
  logic          req_ready [2];
  logic [AW-1:0] req_addr  [2];
  logic          req_we    [2];
  logic [DW-1:0] req_wdata [2];
  logic          rsp_valid [2];
  logic [DW-1:0] rsp_rdata [2];
  logic          flush_req [2];
  logic          flush_done[2];
  logic          mem_req   [2];
  logic          mem_we    [2];
  logic [AW-1:0] mem_addr  [2];
  logic [DW-1:0] mem_wdata [2];
  logic          mem_ack   [2];
  logic [DW-1:0] mem_rdata [2];

  logic [DW-1:0] bmem [2][256];
  logic [DW-1:0] refm [2][256];
  int            cnt    [2];
  int            wr_cnt [2];
  int            rd_cnt [2];
  int            op_no  [2];
  int            last_wr[2];
  int            last_rd[2];
  int            rsp_cnt[2];
  int            hold_err;
  int            tests;
  int            fails;
  exp_t          q0[$];
  exp_t          q1[$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  wpc_cache_top #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2), .WRITE_BACK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_addr(req_addr[0]),
    .req_we(req_we[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]),
    .flush_req(flush_req[0]), .flush_done(flush_done[0]),
    .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
    .mem_wdata(mem_wdata[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0])
  );

  wpc_cache_top #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2), .WRITE_BACK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_addr(req_addr[1]),
    .req_we(req_we[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]),
    .flush_req(flush_req[1]), .flush_done(flush_done[1]),
    .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
    .mem_wdata(mem_wdata[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1])
  );

  function automatic logic [DW-1:0] seed_val(int a);
    return DW'(a * 7 + 3);
  endfunction

  // backing memory model: fixed latency, one-cycle acknowledge
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        for (int a = 0; a < 256; a++) bmem[k][a] <= seed_val(a);
        mem_ack[k] <= 1'b0;
        cnt[k]     <= 0;
        wr_cnt[k]  <= 0;
        rd_cnt[k]  <= 0;
        op_no[k]   <= 0;
        last_wr[k] <= 0;
        last_rd[k] <= 0;
      end else if (mem_ack[k]) begin
        mem_ack[k] <= 1'b0;
        cnt[k]     <= 0;
      end else if (mem_req[k]) begin
        if (cnt[k] == LAT - 1) begin
          mem_ack[k] <= 1'b1;
          op_no[k]   <= op_no[k] + 1;
          if (mem_we[k]) begin
            bmem[k][mem_addr[k]] <= mem_wdata[k];
            wr_cnt[k]  <= wr_cnt[k] + 1;
            last_wr[k] <= op_no[k] + 1;
          end else begin
            mem_rdata[k] <= bmem[k][mem_addr[k]];
            rd_cnt[k]    <= rd_cnt[k] + 1;
            last_rd[k]   <= op_no[k] + 1;
          end
        end else begin
          cnt[k] <= cnt[k] + 1;
        end
      end
    end
  end

  task automatic chk(string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // scoreboard monitor and memory-request hold watcher (R12, R13)
  logic          prev_req [2];
  logic          prev_ack [2];
  logic [AW-1:0] prev_addr[2];
  logic          prev_we  [2];
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst_n) begin
        if (prev_req[k] && !prev_ack[k] &&
            (!mem_req[k] || mem_addr[k] !== prev_addr[k] || mem_we[k] !== prev_we[k]))
          hold_err++;
        if (rsp_valid[k]) begin
          exp_t e;
          rsp_cnt[k]++;
          if ((k == 0 && q0.size() == 0) || (k == 1 && q1.size() == 0)) begin
            tests++; fails++;
            $display("FAIL R13 unexpected response actual=1 expected=0");
          end else begin
            e = (k == 0) ? q0.pop_front() : q1.pop_front();
            if (e.rd) chk(e.tag, rsp_rdata[k], e.d);
          end
        end
      end
      prev_req[k]  = mem_req[k];
      prev_ack[k]  = mem_ack[k];
      prev_addr[k] = mem_addr[k];
      prev_we[k]   = mem_we[k];
    end
  end

  task automatic xfer(int k, bit we, logic [AW-1:0] a, logic [DW-1:0] d, string rq);
    exp_t e;
    int base;
    e.rd  = !we;
    e.d   = refm[k][a];
    e.tag = rq;
    if (we) refm[k][a] = d;
    if (k == 0) q0.push_back(e); else q1.push_back(e);
    base = rsp_cnt[k];
    @(negedge clk);
    req_valid[k] = 1'b1;
    req_addr[k]  = a;
    req_we[k]    = we;
    req_wdata[k] = d;
    while (!req_ready[k]) @(negedge clk);
    @(negedge clk);
    req_valid[k] = 1'b0;
    for (int n = 0; n < 100 && rsp_cnt[k] == base; n++) @(negedge clk);
    chk({rq, " response"}, 32'(rsp_cnt[k] - base), 32'd1);
  endtask

  task automatic flush(int k, string rq);
    int n;
    @(negedge clk);
    flush_req[k] = 1'b1;
    #1;
    chk("R11 ready low with flush_req", {31'd0, req_ready[k]}, 32'd0);
    @(negedge clk);
    flush_req[k] = 1'b0;
    chk("R11 ready low during scan", {31'd0, req_ready[k]}, 32'd0);
    n = 0;
    while (!flush_done[k] && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({rq, " flush_done"}, {31'd0, flush_done[k]}, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; hold_err = 0;
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = 0; req_addr[k] = '0; req_we[k] = 0; req_wdata[k] = '0;
      flush_req[k] = 0; rsp_cnt[k] = 0;
      prev_req[k] = 0; prev_ack[k] = 0; prev_addr[k] = '0; prev_we[k] = 0;
      for (int a = 0; a < 256; a++) refm[k][a] = seed_val(a);
    end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 ready in reset u0", {31'd0, req_ready[0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready during sweep u0", {31'd0, req_ready[0]}, 32'd0);
    chk("R1 ready during sweep u1", {31'd0, req_ready[1]}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R1 ready after sweep u0", {31'd0, req_ready[0]}, 32'd1);
    chk("R1 ready after sweep u1", {31'd0, req_ready[1]}, 32'd1);

    // ---- write-back instance ----
    xfer(0, 0, 8'h05, '0, "R3 read miss data");
    chk("R1 R3 first read misses", 32'(rd_cnt[0]), 32'd1);
    chk("R3 no write", 32'(wr_cnt[0]), 32'd0);
    xfer(0, 0, 8'h05, '0, "R2 read hit data");
    chk("R2 hit no memory read", 32'(rd_cnt[0]), 32'd1);
    xfer(0, 1, 8'h05, 32'hAAAA_0005, "R6 write hit");
    chk("R6 no memory write", 32'(wr_cnt[0]), 32'd0);
    chk("R6 memory unchanged", bmem[0][8'h05], seed_val(5));
    xfer(0, 0, 8'h05, '0, "R6 read after write hit");
    xfer(0, 0, 8'h09, '0, "R7 read after dirty eviction");
    chk("R7 one write back", 32'(wr_cnt[0]), 32'd1);
    chk("R7 one fill", 32'(rd_cnt[0]), 32'd2);
    chk("R7 victim value in memory", bmem[0][8'h05], 32'hAAAA_0005);
    chk("R7 write before read", {31'd0, last_wr[0] < last_rd[0]}, 32'd1);
    xfer(0, 1, 8'h12, 32'h5555_1234, "R8 write miss");
    chk("R8 fetch on write miss", 32'(rd_cnt[0]), 32'd3);
    chk("R8 no memory write", 32'(wr_cnt[0]), 32'd1);
    chk("R8 memory unchanged", bmem[0][8'h12], seed_val(8'h12));
    xfer(0, 0, 8'h12, '0, "R8 read after write miss");
    chk("R8 read hits", 32'(rd_cnt[0]), 32'd3);
    flush(0, "R10");
    chk("R10 dirty line written", 32'(wr_cnt[0]), 32'd2);
    chk("R10 flushed value", bmem[0][8'h12], 32'h5555_1234);
    flush(0, "R10 second");
    chk("R10 second flush writes nothing", 32'(wr_cnt[0]), 32'd2);
    xfer(0, 0, 8'h16, '0, "R9 clean eviction read");
    chk("R9 no write on clean victim", 32'(wr_cnt[0]), 32'd2);
    chk("R9 fill issued", 32'(rd_cnt[0]), 32'd4);

    // ---- write-through instance ----
    xfer(1, 0, 8'h05, '0, "R3 wt read miss");
    chk("R3 wt fill", 32'(rd_cnt[1]), 32'd1);
    xfer(1, 1, 8'h05, 32'hBBBB_0005, "R4 wt write hit");
    chk("R4 memory written", 32'(wr_cnt[1]), 32'd1);
    chk("R4 memory value", bmem[1][8'h05], 32'hBBBB_0005);
    xfer(1, 0, 8'h05, '0, "R4 line updated");
    chk("R4 read hit after write", 32'(rd_cnt[1]), 32'd1);
    xfer(1, 1, 8'h0A, 32'hCCCC_000A, "R5 wt write miss");
    chk("R5 memory written", 32'(wr_cnt[1]), 32'd2);
    chk("R5 no fetch", 32'(rd_cnt[1]), 32'd1);
    chk("R5 memory value", bmem[1][8'h0A], 32'hCCCC_000A);
    xfer(1, 0, 8'h0A, '0, "R5 read after write miss");
    chk("R5 not allocated", 32'(rd_cnt[1]), 32'd2);
    flush(1, "R10 wt");
    chk("R10 wt flush writes nothing", 32'(wr_cnt[1]), 32'd2);

    repeat (3) @(negedge clk);
    chk("R12 memory request held", 32'(hold_err), 32'd0);
    chk("R13 all responses seen", 32'(q0.size() + q1.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule